// File: doc/BRIEF.md
# Status Register with Pin-Qualified Block Protection

This block keeps the 8-bit software status byte of a serial flash controller and decides which array addresses are shielded from program and erase. The command sequencer reports each finished instruction as a one-cycle `instr_done` pulse. The pulse carries the opcode and, for a status write, the data byte. The sequencer also supplies the live busy, write-enable and auto-increment flags. The block returns the assembled status byte and a combinational `addr_prot` flag for any 17-bit address offered by the array path.

Status writes are guarded in two ways. First, a small arming machine with the states `ST_IDLE` and `ST_ARMED` ensures that a status write is accepted only when the instruction completed just before it was the arming opcode. The transitions are:

- `T_ARM` moves any state to `ST_ARMED` on opcode 50h.
- `T_CONSUME` moves `ST_ARMED` to `ST_IDLE` on any other opcode.
- `T_STAY` keeps `ST_IDLE` on non-arming opcodes.

Second, a lock bit in the register works together with an external active-low lock pin. The pin is synchronized before use. While the pin is low, a set lock bit freezes the protection fields.

Top module: `stat_guard`

## Requirements
- R1: After reset with the flag inputs low, `status` reads 0Ch: protection field (bits 3:2) = 11, lock bit (bit 7) = 0, every other bit 0.
- R2: Bit 0 equals `busy_in`, bit 1 equals `wel_in` and bit 6 equals `aai_in` in the same cycle. Bits 5:4 always read 0.
- R3: A status write (opcode 01h) accepted after arming copies `wr_data[7]`, `wr_data[3]` and `wr_data[2]` into bits 7, 3 and 2. The other data bits have no effect on `status`.
- R4: A status write whose directly preceding completed instruction was not 50h leaves `status` unchanged. This includes the case where another opcode comes between the arming instruction and the write.
- R5: With the synchronized pin low and the lock bit at 1, an armed status write leaves bits 7, 3 and 2 unchanged.
- R6: With the synchronized pin low and the lock bit at 0, one armed write can set the lock bit and change both protection bits together. Once set, the lock bit stays 1 while the pin is low.
- R7: With the synchronized pin high, an armed write can change all three writable bits, including clearing the lock bit.
- R8: `addr_prot` follows the protection field (bits 3:2): 00 protects nothing, 01 protects 18000h–1FFFFh, 10 protects 10000h–1FFFFh, and 11 protects the whole space.
- R9: The pin passes through two synchronizing flops. A write completing on the first clock edge after the pin rises is still judged with the pin low, while writes three cycles later see it high.
- R10: Repeated arming opcodes keep the machine armed, so a status write directly after the second of two 50h opcodes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_done | input | 1 | One-cycle pulse: an instruction completed |
| instr_code | input | 8 | Opcode of the completed instruction |
| wr_data | input | 8 | Data byte of a completed status write |
| lock_pin_n | input | 1 | Asynchronous active-low lock pin |
| busy_in | input | 1 | Internal operation in progress |
| wel_in | input | 1 | Write-enable latch state |
| aai_in | input | 1 | Auto-increment programming active |
| addr | input | 17 | Array address to classify |
| status | output | 8 | Assembled status byte |
| addr_prot | output | 1 | Address lies in the protected region |

## Verification
Instruction streams are drawn at random from arming, status-write, write-enable and unrelated opcodes, with random data bytes and pin levels. An expected model tells apart accepted writes, unarmed writes and locked writes. Directed sequences test the cases that random streams rarely hit: an intervening opcode between arming and writing, double arming, setting the lock bit together with the protection bits, and clearing it with the pin high. A write issued one cycle after the pin rises separates a correctly synchronized pin from a direct one. Random addresses across all four protection levels, together with the exact region edges 0FFFFh/10000h and 17FFFh/18000h, separate the decode thresholds.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

    localparam logic [7:0] OP_ARM_STAT = 8'h50;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;

    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_BP0  = 2;
    localparam int BIT_BP1  = 3;
    localparam int BIT_AAI  = 6;
    localparam int BIT_LOCK = 7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_level_t;

endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/stat_arm_fsm.sv
module stat_arm_fsm
    import stat_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_done,
    input  logic [7:0] instr_code,
    output logic       write_go
);
    arm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        write_go = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_done && instr_code == OP_ARM_STAT) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (instr_done) begin
                    if (instr_code == OP_ARM_STAT) begin
                        state_d = ST_ARMED;
                    end else begin
                        state_d  = ST_IDLE;
                        write_go = (instr_code == OP_WR_STAT);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R10: an arming opcode always leaves the machine armed
    assert_arm_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && instr_code == OP_ARM_STAT) |=> (state_q == ST_ARMED));

    // R4: without a completed instruction the machine holds its state
    assert_hold_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> $stable(state_q));

    // R4: a write is only launched out of the armed state
    assert_go_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        write_go |-> (state_q == ST_ARMED));
endmodule

// File: rtl/stat_prot_reg.sv
module stat_prot_reg
    import stat_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       write_go,
    input  logic [7:0] wr_data,
    input  logic       pin_hi,
    output logic [1:0] bp,
    output logic       lock
);
    logic [1:0] bp_q;
    logic       lock_q;
    logic       allowed;

    assign allowed = pin_hi || !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q   <= 2'b11;
            lock_q <= 1'b0;
        end else if (write_go && allowed) begin
            bp_q   <= {wr_data[BIT_BP1], wr_data[BIT_BP0]};
            lock_q <= wr_data[BIT_LOCK];
        end
    end

    assign bp   = bp_q;
    assign lock = lock_q;

    // R4: no launch, no change
    assert_quiet_without_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !write_go |=> ($stable(bp_q) && $stable(lock_q)));

    // R5: locked with the pin low freezes the fields
    assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (write_go && !pin_hi && lock_q) |=> ($stable(bp_q) && $stable(lock_q)));

    // R6: the lock bit cannot fall while the pin is low
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !pin_hi) |=> lock_q);
endmodule

// File: rtl/stat_region_dec.sv
module stat_region_dec
    import stat_guard_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (prot_level_t'(bp))
            PROT_NONE:    prot = 1'b0;
            PROT_QUARTER: prot = (addr[TOP -: 2] == 2'b11);
            PROT_HALF:    prot = addr[TOP];
            PROT_ALL:     prot = 1'b1;
            default:      prot = 1'b1;
        endcase
    end

    // R8: the highest address is protected whenever any level is set
    always_comb begin
        if (bp != 2'b00 && addr == {ADDR_W{1'b1}})
            assert_top_covered_R8: assert (prot);
    end
endmodule

// File: rtl/stat_guard.sv
module stat_guard
    import stat_guard_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic [7:0]        instr_code,
    input  logic [7:0]        wr_data,
    input  logic              lock_pin_n,
    input  logic              busy_in,
    input  logic              wel_in,
    input  logic              aai_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        status,
    output logic              addr_prot
);
    logic       pin_hi;
    logic       write_go;
    logic [1:0] bp;
    logic       lock;

    stat_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (lock_pin_n),
        .q_sync  (pin_hi)
    );

    stat_arm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .instr_code (instr_code),
        .write_go   (write_go)
    );

    stat_prot_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .write_go (write_go),
        .wr_data  (wr_data),
        .pin_hi   (pin_hi),
        .bp       (bp),
        .lock     (lock)
    );

    stat_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bp   (bp),
        .addr (addr),
        .prot (addr_prot)
    );

    always_comb begin
        status           = 8'h00;
        status[BIT_BUSY] = busy_in;
        status[BIT_WEL]  = wel_in;
        status[BIT_BP0]  = bp[0];
        status[BIT_BP1]  = bp[1];
        status[BIT_AAI]  = aai_in;
        status[BIT_LOCK] = lock;
    end

    // R7: with the pin high an armed write always lands its lock bit
    assert_unlocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (write_go && pin_hi) |=> (lock == $past(wr_data[BIT_LOCK])));
endmodule

// File: tb/stat_guard_bench.sv
module stat_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 1'b0;
    logic [7:0]  instr_code = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        lock_pin_n = 1'b0;
    logic        busy_in = 1'b0, wel_in = 1'b0, aai_in = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  status;
    logic        addr_prot;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic [1:0] m_bp = 2'b11;
    logic       m_lock = 1'b0;
    logic       m_armed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_guard u_stat_guard (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .instr_code(instr_code),
        .wr_data(wr_data), .lock_pin_n(lock_pin_n), .busy_in(busy_in), .wel_in(wel_in),
        .aai_in(aai_in), .addr(addr), .status(status), .addr_prot(addr_prot)
    );

    function automatic logic [7:0] exp_status(logic [1:0] bpv, logic lk, logic b, logic w, logic a);
        return {lk, a, 2'b00, bpv, w, b};
    endfunction

    function automatic logic exp_prot(logic [1:0] bpv, logic [16:0] ad);
        case (bpv)
            2'b00:   return 1'b0;
            2'b01:   return ad >= 17'h18000;
            2'b10:   return ad >= 17'h10000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pin_now: synchronized level the design sees at the commit edge
    task automatic issue(logic [7:0] code, logic [7:0] data, logic pin_now);
        instr_code = code;
        wr_data    = data;
        instr_done = 1'b1;
        if (code == 8'h50) begin
            m_armed = 1'b1;
        end else begin
            if (m_armed && code == 8'h01 && (pin_now || !m_lock)) begin
                m_bp   = {data[3], data[2]};
                m_lock = data[7];
            end
            m_armed = 1'b0;
        end
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic check_status(string req);
        check(req, {24'h0, status}, {24'h0, exp_status(m_bp, m_lock, busy_in, wel_in, aai_in)});
    endtask

    task automatic set_pin(logic v);
        lock_pin_n = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {24'h0, status}, 32'h0C);
        addr = 17'h00000; #1;
        check("R8", {31'h0, addr_prot}, 1);

        // R2 mirror bits
        busy_in = 1; wel_in = 1; aai_in = 1; #1;
        check("R2", {24'h0, status}, 32'h4F);
        busy_in = 0; wel_in = 0; aai_in = 0;

        // R4 unarmed write, and arm-other-write
        issue(8'h01, 8'h00, 0); check_status("R4");
        issue(8'h50, 8'h00, 0); issue(8'h06, 8'h00, 0); issue(8'h01, 8'h00, 0);
        check("R4", {24'h0, status}, 32'h0C);

        // R3 accepted write, junk bits ignored (pin low, lock 0)
        issue(8'h50, 8'h00, 0); issue(8'h01, 8'h73, 0);
        check("R3", {24'h0, status}, 32'h00);

        // R10 double arm
        issue(8'h50, 8'h00, 0); issue(8'h50, 8'h00, 0); issue(8'h01, 8'h08, 0);
        check("R10", {24'h0, status}, 32'h08);

        // R6 set lock and BP together with pin low
        issue(8'h50, 8'h00, 0); issue(8'h01, 8'h84, 0);
        check("R6", {24'h0, status}, 32'h84);

        // R5 locked: write ignored
        issue(8'h50, 8'h00, 0); issue(8'h01, 8'h00, 0);
        check("R5", {24'h0, status}, 32'h84);

        // R8 edges at quarter
        addr = 17'h17FFF; #1; check("R8", {31'h0, addr_prot}, 0);
        addr = 17'h18000; #1; check("R8", {31'h0, addr_prot}, 1);

        // R9 pin rises; write commits on first edge, still locked
        issue(8'h50, 8'h00, 0);
        lock_pin_n = 1'b1;
        issue(8'h01, 8'h08, 0);
        check("R9", {24'h0, status}, 32'h84);
        repeat (2) @(negedge clk);

        // R7 pin high: clear lock
        issue(8'h50, 8'h00, 1); issue(8'h01, 8'h08, 1);
        check("R7", {24'h0, status}, 32'h08);
        addr = 17'h0FFFF; #1; check("R8", {31'h0, addr_prot}, 0);
        addr = 17'h10000; #1; check("R8", {31'h0, addr_prot}, 1);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [7:0] code;
            if (i % 25 == 0) set_pin(1'($urandom_range(0, 1)));
            sel = $urandom_range(0, 3);
            case (sel)
                0: code = 8'h50;
                1: code = 8'h01;
                2: code = 8'h06;
                default: code = 8'($urandom);
            endcase
            busy_in = 1'($urandom); wel_in = 1'($urandom); aai_in = 1'($urandom);
            issue(code, 8'($urandom), lock_pin_n);
            check_status(code == 8'h01 ? "R3" : "R2");
            addr = 17'($urandom); #1;
            check("R8", {31'h0, addr_prot}, {31'h0, exp_prot(m_bp, addr)});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule